// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor-side engine that carries out one read or one write over a shared bus. The bus has 20 address bits and 16 data bits, and address and data use the same pins. Each transfer moves through four phases: an address phase, a turnaround phase, a transfer phase and a closing phase. A slow target can hold the transfer phase open for as long as it needs by lowering `readyIn`. Each extra cycle it adds is a wait phase.

Inside the chip, a requester presents an address, write data, a direction bit and a memory/I-O select. `reqAccept` tells it in which cycle the request was taken. The block answers with a one-cycle `done` strobe. On a read, the captured word is on `rdData` in that same cycle.

On the bus side, the block drives:
- an address-latch strobe that an external latch uses to hold the address;
- active-low read, write and transceiver-enable strobes;
- a transmit/receive direction line and an I-O select line;
- the shared pins, through `adOut` and the output enable `adOe`. Read data comes back on `adIn`.

Top module: `busCycleSeq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `ale` is 0, `rdN`, `wrN` and `denN` are 1, `adOe` is 0 and `done` is 0.
- R2: In the cycle after a request is accepted (address phase), `ale` is 1, `adOe` is 1 and `adOut` equals the request address. From that cycle until the next acceptance, `dtR` equals the direction bit (1 = write) and `ioSel` equals the select bit (1 = I-O).
- R3: `ale` is high for exactly one cycle per transfer and is 0 in every other phase.
- R4: On a read, `adOe` is 0 from the second phase through the closing phase. `rdN` is 0 in the second and transfer phases and in every wait phase, and is 1 in the closing phase. `denN` is 0 from the transfer phase through the closing phase.
- R5: On a write, `adOe` is 1 from the second phase through the closing phase, and `adOut` carries the write data in bits 15:0 with bits 19:16 zero. `wrN` is 0 in the transfer phase and in wait phases, and is 1 in the closing phase. `denN` is 0 from the second phase through the closing phase.
- R6: With `readyIn` high, a transfer takes exactly four cycles. `done` is high in the fourth cycle after the accepting clock edge.
- R7: `readyIn` is sampled on the edge that ends the transfer phase or a wait phase. If it is 0, another wait phase follows, with no upper limit. If it is 1, the closing phase follows.
- R8: During every wait phase, `adOut`, `adOe`, `rdN`, `wrN`, `denN`, `dtR` and `ioSel` keep the values they had in the transfer phase.
- R9: `done` is high for one cycle, in the closing phase. On a read, `rdData` in that cycle equals the value `adIn` had at the edge that ended the last transfer or wait phase.
- R10: `reqAccept` is 1 exactly when `reqValid` is 1 and the block is idle or in a closing phase. An acceptance in the closing phase starts the next address phase on the very next cycle.
- R11: None of `rdN`, `wrN` or `denN` is 0 while `ale` is 1, and `rdN` and `wrN` are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqAddr | input | 20 | Transfer address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I-O space, 0 = memory |
| reqWdata | input | 16 | Write data |
| reqAccept | output | 1 | Request taken at this clock edge |
| done | output | 1 | Closing phase, one-cycle completion strobe |
| rdData | output | 16 | Captured read data |
| ale | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | Transceiver direction, 1 = transmit |
| ioSel | output | 1 | 1 = I-O cycle, 0 = memory |
| adOut | output | 20 | Value driven onto the shared pins |
| adOe | output | 1 | Shared-pin output enable |
| adIn | input | 16 | Data sampled from the shared pins |
| readyIn | input | 1 | Target ready, 0 inserts wait phases |

## Verification
A phase register that skips or repeats a state shows up at once. The strobe pattern and the `ale` pulse stop matching the reference within one cycle, and `done` arrives early or late against the counted latency.

A wrongly latched direction or select bit shows up in the address phase of the first affected transfer, on `dtR` and `ioSel`. A fault in the capture timing only shows up in `rdData` at `done`. For this reason `adIn` changes every cycle in the bench, so that a capture one edge too early or too late gives a different word.

Wait handling is tested with runs of zero, one, two and seven wait phases, and with back-to-back transfers that are accepted in the closing phase.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5
  } busState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadReq;    // latch request fields at this edge
    logic driveAddr;  // put address on shared pins
    logic driveData;  // put write data on shared pins
    logic captureRd;  // sample adIn at this edge
    logic waitPhase;  // current phase is a wait phase
  } dpCtl_t;

endpackage

// File: rtl/busSeqData.sv
module busSeqData
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic              cycleWrite,
  output logic              ioSel,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;
  logic              ioQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
      ioQ    <= 1'b0;
    end else if (ctl.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
      ioQ    <= reqIo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (ctl.captureRd) begin
      rdQ <= adIn;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign adOut = ctl.driveAddr ? addrQ : {{PAD_W{1'b0}}, wdataQ};
    end else begin : g_nopad
      assign adOut = ctl.driveAddr ? addrQ : wdataQ[ADDR_W-1:0];
    end
  endgenerate

  assign adOe       = ctl.driveAddr | ctl.driveData;
  assign cycleWrite = writeQ;
  assign ioSel      = ioQ;
  assign rdData     = rdQ;

  // R8: shared pins hold still through each wait phase
  p_pins_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.waitPhase |-> ($stable(adOut) && $stable(adOe) && $stable(ioSel)));

endmodule

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   cycleWrite,
  input  logic   readyIn,
  output dpCtl_t ctl,
  output logic   reqAccept,
  output logic   done,
  output logic   ale,
  output logic   rdN,
  output logic   wrN,
  output logic   denN
);

  busState_e state, stateNext;
  logic      xferPhase;   // transfer or wait phase
  logic      dataPhase;   // second phase through closing phase

  assign xferPhase = (state == S_T3) || (state == S_TW);
  assign dataPhase = (state == S_T2) || xferPhase || (state == S_T4);
  assign reqAccept = reqValid && ((state == S_IDLE) || (state == S_T4));

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  stateNext = reqAccept ? S_T1 : S_IDLE;
      S_T1:    stateNext = S_T2;
      S_T2:    stateNext = S_T3;
      S_T3,
      S_TW:    stateNext = readyIn ? S_T4 : S_TW;
      S_T4:    stateNext = reqAccept ? S_T1 : S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.loadReq   = reqAccept;
    ctl.driveAddr = (state == S_T1);
    ctl.driveData = cycleWrite && dataPhase;
    ctl.captureRd = xferPhase && readyIn && !cycleWrite;
    ctl.waitPhase = (state == S_TW);
  end

  assign ale  = (state == S_T1);
  assign done = (state == S_T4);
  assign rdN  = !(!cycleWrite && ((state == S_T2) || xferPhase));
  assign wrN  = !(cycleWrite && xferPhase);
  assign denN = !(cycleWrite ? dataPhase : (xferPhase || (state == S_T4)));

  // R11: no active-low strobe while the address latch strobe is high
  p_strobe_vs_ale_r11: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && denN));
  // R11: read and write strobes never overlap
  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  // R3: latch strobe lasts one cycle
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  // R7: low ready adds a wait phase
  p_wait_on_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferPhase && !readyIn) |=> (state == S_TW));
  // R7: high ready closes the transfer
  p_close_on_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferPhase && readyIn) |=> done);
  // R9: completion strobe lasts one cycle
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: an acceptance always opens an address phase
  p_accept_opens_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> ale);
  // R8: bus strobes hold through a wait phase
  p_strobes_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TW) |-> ($stable(rdN) && $stable(wrN) && $stable(denN)));
  // R2: direction bit is taken from the accepted request
  p_dir_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> (cycleWrite == $past(reqWrite)));

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAccept,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              denN,
  output logic              dtR,
  output logic              ioSel,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  input  logic              readyIn
);

  dpCtl_t ctl;
  logic   cycleWrite;

  busSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .cycleWrite(cycleWrite),
    .readyIn   (readyIn),
    .ctl       (ctl),
    .reqAccept (reqAccept),
    .done      (done),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN),
    .denN      (denN)
  );

  busSeqData #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqWrite  (reqWrite),
    .reqIo     (reqIo),
    .adIn      (adIn),
    .adOut     (adOut),
    .adOe      (adOe),
    .cycleWrite(cycleWrite),
    .ioSel     (ioSel),
    .rdData    (rdData)
  );

  assign dtR = cycleWrite;

endmodule

// File: tb/busCycleSeq_bench.sv
module busCycleSeq_bench;

  localparam int NTX = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [19:0] reqAddr;
  logic        reqWrite;
  logic        reqIo;
  logic [15:0] reqWdata;
  logic        reqAccept, done, ale, rdN, wrN, denN, dtR, ioSel, adOe;
  logic [15:0] rdData;
  logic [19:0] adOut;
  logic [15:0] adIn;
  logic        readyIn;

  always #5 clk = ~clk;

  busCycleSeq u_busCycleSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqIo(reqIo), .reqWdata(reqWdata),
    .reqAccept(reqAccept), .done(done), .rdData(rdData), .ale(ale),
    .rdN(rdN), .wrN(wrN), .denN(denN), .dtR(dtR), .ioSel(ioSel),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .readyIn(readyIn)
  );

  int nVec  = 0;
  int nFail = 0;

  // reference model state: 0 idle, 1 addr, 2 turn, 3 xfer, 4 wait, 5 close
  int          ph = 0;
  logic        mWr = 1'b0, mIo = 1'b0;
  logic [19:0] mAddr = '0, prevAdOut = '0;
  logic [15:0] mWd = '0, mRd = '0;
  int          waitLeft = 0, gapLeft = 0, txIdx = 0, cyc = 0;
  int          accCyc = 0, accWaits = 0;

  function automatic logic [19:0] txAddr(int i);
    logic [31:0] t = 32'h0A5C3 + i * 32'h1B2D7;
    return t[19:0];
  endfunction
  function automatic logic [15:0] txWdata(int i);
    logic [31:0] t = 32'h3C5A + i * 32'h0F1E1;
    return t[15:0];
  endfunction
  function automatic logic txWrite(int i); return (i % 3) != 0; endfunction
  function automatic logic txIo(int i);    return (i % 4) == 2; endfunction
  function automatic int txWaits(int i);   return (i == 5) ? 7 : (i % 3); endfunction
  function automatic int txGap(int i);     return (i % 5 == 0) ? 3 : 0; endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string tg(string dflt);
    if (ph == 0) return "R1";
    if (ph == 4) return "R8";
    return dflt;
  endfunction

  task automatic compareAll();
    logic expOe;
    expOe = (ph == 1) || (mWr && ph >= 2);
    chk(ale,  ph == 1, (ph == 1) ? "R2" : tg("R3"), "ale");
    chk(rdN,  !(!mWr && ph >= 2 && ph <= 4), tg("R4"), "rdN");
    chk(wrN,  !(mWr && (ph == 3 || ph == 4)), tg("R5"), "wrN");
    chk(denN, !(mWr ? (ph >= 2) : (ph >= 3)), tg(mWr ? "R5" : "R4"), "denN");
    chk(adOe, expOe, (ph == 1) ? "R2" : tg(mWr ? "R5" : "R4"), "adOe");
    if (ph == 1) chk(adOut, mAddr, "R2", "adOut addr");
    else if (expOe) chk(adOut, {4'h0, mWd}, tg("R5"), "adOut data");
    if (ph == 4) chk(adOut, prevAdOut, "R8", "adOut hold");
    chk(dtR,   mWr, "R2", "dtR");
    chk(ioSel, mIo, "R2", "ioSel");
    chk(done,  ph == 5, tg("R9"), "done");
    if (ph == 5 && !mWr) chk(rdData, mRd, "R9", "rdData");
    chk(reqAccept, reqValid && (ph == 0 || ph == 5), "R10", "reqAccept");
    chk(((ale && (!rdN || !wrN || !denN)) || (!rdN && !wrN)), 1'b0, "R11", "strobe overlap");
    if (ph == 5) chk(cyc - accCyc, 4 + accWaits, (accWaits == 0) ? "R6" : "R7", "latency");
    prevAdOut = adOut;
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0; reqIo = 1'b0;
    reqWdata = '0; adIn = '0; readyIn = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(ale, 1'b0, "R1", "ale in reset");
    chk({rdN, wrN, denN}, 3'b111, "R1", "strobes in reset");
    chk(adOe, 1'b0, "R1", "adOe in reset");
    chk(done, 1'b0, "R1", "done in reset");
    @(negedge clk);
    rstN = 1'b1;
    while ((txIdx < NTX || ph != 0) && cyc < 20000) begin
      @(negedge clk);
      reqValid = (txIdx < NTX) && (gapLeft == 0);
      reqAddr  = txAddr(txIdx);
      reqWdata = txWdata(txIdx);
      reqWrite = txWrite(txIdx);
      reqIo    = txIo(txIdx);
      readyIn  = !((ph == 3 || ph == 4) && waitLeft > 0);
      adIn     = 16'hC000 ^ (cyc[15:0] * 16'h0135);
      #1;
      compareAll();
      @(posedge clk);
      begin
        logic acc;
        acc = reqValid && (ph == 0 || ph == 5);
        case (ph)
          0:       ph = acc ? 1 : 0;
          1:       ph = 2;
          2:       ph = 3;
          3, 4: begin
            if (readyIn) begin
              if (!mWr) mRd = adIn;
              ph = 5;
            end else begin
              ph = 4;
              waitLeft--;
            end
          end
          default: ph = acc ? 1 : 0;
        endcase
        if (!reqValid && gapLeft > 0) gapLeft--;
        if (acc) begin
          mAddr = reqAddr; mWd = reqWdata; mWr = reqWrite; mIo = reqIo;
          waitLeft = txWaits(txIdx); accWaits = waitLeft; accCyc = cyc;
          txIdx++;
          gapLeft = (txIdx < NTX) ? txGap(txIdx) : 0;
        end
      end
      cyc++;
    end
    if (cyc >= 20000) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: time limit reached, actual tx %0d expected %0d", txIdx, NTX);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule